// File: doc/BRIEF.md
# Multi-Mode Iterative Divider

This block divides a signed or unsigned dividend by a 16-bit divisor. It produces one quotient bit per cycle and returns a 16-bit quotient and a 16-bit remainder. One engine handles five operation types: a Q15 fractional divide, signed and unsigned divides of a 32-bit dividend, and signed and unsigned divides of a 16-bit dividend. Every type runs the same fixed number of steps. A host raises `start` for one cycle with the operands and the mode. It then supplies steps through `step_en` until `done` pulses.

A run is one setup cycle followed by 18 iteration steps. The first step widens the latched dividend to 32 bits and takes its magnitude. Sixteen restoring steps follow, one per quotient bit. The last step applies the signs and checks the range. The host can drop `step_en` at any point after setup. Progress then freezes and picks up at the same step when the enable returns. Nothing starts or completes unless the host asks for it.

Top module: `itdiv_top`

## Requirements
- R1: Mode code 2 divides the full 32-bit `dividend` as an unsigned number by the unsigned `divisor`. It returns the floor quotient and the remainder.
- R2: Mode code 1 divides the 32-bit `dividend` as a two's-complement number by the signed `divisor`. The quotient truncates toward zero, and a nonzero remainder has the sign of the dividend.
- R3: Mode codes 3 (signed) and 4 (unsigned) divide only `dividend[15:0]`, sign-extended or zero-extended, and ignore the upper half. Codes 5 to 7 act as code 4.
- R4: Mode code 0 treats `dividend[15:0]` and `divisor` as Q15 values. The quotient is the truncated signed value of (dividend * 32768) / divisor, and the remainder of that division has the sign of the dividend.
- R5: With `step_en` held high, `done` is high in the cycle after the 19th rising edge following the edge that samples `start`. `busy` is high from the cycle after that sampling edge until `done` rises.
- R6: Each rising edge after the setup edge at which `step_en` is low delays `done` by one cycle. The result does not change.
- R7: A zero divisor gives `div_zero`=1, `ovf`=0, and a quotient and remainder of 16'hFFFF.
- R8: A quotient outside the range of the mode (0..65535 unsigned, -32768..32767 signed) with a nonzero divisor gives `ovf`=1, `div_zero`=0, and a quotient and remainder of 16'hFFFF.
- R9: A `start` sampled while `busy` is high has no effect. The running divide completes with its own operands and timing.
- R10: `done` stays high for exactly one cycle. The quotient, remainder and flags hold their values until the next completion.
- R11: After reset, `busy`, `done`, `div_zero`, `ovf`, `quotient` and `remainder` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a divide (taken only while idle) |
| mode | input | 3 | Operation type code |
| dividend | input | 32 | Dividend; only bits 15:0 are used in 16-bit and fractional modes |
| divisor | input | 16 | Divisor |
| step_en | input | 1 | Allows an iteration step on this edge |
| quotient | output | 16 | Quotient result |
| remainder | output | 16 | Remainder result |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last divide had a zero divisor |
| ovf | output | 1 | Last quotient was out of range |

## Verification
The bench goes after the signed edges: -32768 / -1 in the 16-bit signed mode, and -0.5 / 0.5 in Q15, which must fit at exactly -32768. A sign correction that is off by one would either flag the fitting case or wrap the overflowing one. A garbage upper half in the narrow modes catches a first step that does not extend the dividend. A 32-bit dividend whose upper word equals the divisor catches a missing quotient-width check. A pause in the middle of the divide and a `start` pulse during the run catch a counter or partial remainder that moves without `step_en`, or a restart that corrupts the running divide. Both show up as a changed latency or a wrong result.

// File: rtl/itdiv_pkg.sv
// Shared types for the iterative divider.
// Holds the operation mode codes, the controller states and a helper
// that says whether a mode is signed.
package itdiv_pkg;

    typedef enum logic [2:0] {
        MD_FRAC = 3'd0,
        MD_S32  = 3'd1,
        MD_U32  = 3'd2,
        MD_S16  = 3'd3,
        MD_U16  = 3'd4
    } div_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2
    } div_state_e;

    // True for the modes whose operands are two's complement.
    function automatic logic mode_is_signed(input logic [2:0] m);
        return (m == MD_FRAC) || (m == MD_S32) || (m == MD_S16);
    endfunction

endpackage

// File: rtl/itdiv_ctrl.sv
// Sequencer of the iterative divider.
// Accepts start only while idle, spends one setup cycle, then counts
// STEPS iteration steps, each one taken only on an edge where step_en
// is high. It decodes which kind of step is due and pulses done once
// after the final step.
// Assumes STEPS >= 3 (one widening step, at least one bit step, one
// final step).
module itdiv_ctrl
    import itdiv_pkg::*;
#(
    parameter int STEPS = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic step_en,
    output logic busy,
    output logic load,
    output logic setup,
    output logic first_step,
    output logic mid_step,
    output logic last_step,
    output logic done
);
    localparam int CW = $clog2(STEPS);
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    div_state_e     st;
    logic [CW-1:0]  cnt;
    logic           fire;

    // Decode the step type due on this edge.
    always_comb begin
        fire       = (st == ST_RUN) && step_en;
        busy       = (st != ST_IDLE);
        load       = (st == ST_IDLE) && start;
        setup      = (st == ST_SETUP);
        first_step = fire && (cnt == '0);
        last_step  = fire && (cnt == LAST);
        mid_step   = fire && (cnt != '0) && (cnt != LAST);
    end

    // State, step counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= last_step;
            case (st)
                ST_IDLE: if (start) st <= ST_SETUP;
                ST_SETUP: begin
                    st  <= ST_RUN;
                    cnt <= '0;
                end
                ST_RUN: if (fire) begin
                    if (cnt == LAST) st <= ST_IDLE;
                    else             cnt <= cnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/itdiv_prep.sv
// Operand conditioning, purely combinational.
// Widens the latched raw dividend to 2W bits according to the mode:
// the fractional mode shifts left by W-1, the narrow modes sign- or
// zero-extend. It then returns the magnitude halves and the sign, and
// the divisor magnitude and sign.
// Assumes the caller latches the raw operands; codes above 4 act as
// the unsigned narrow mode.
module itdiv_prep
    import itdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]     mode,
    input  logic [2*W-1:0] raw_dvd,
    input  logic [W-1:0]   raw_dvs,
    output logic           is_signed,
    output logic           n_neg,
    output logic           d_neg,
    output logic [W-1:0]   mag_hi,
    output logic [W-1:0]   mag_lo,
    output logic [W-1:0]   dmag
);
    localparam int DW = 2 * W;

    logic [W-1:0]  lo;
    logic [DW-1:0] ext;
    logic [DW-1:0] mag;

    // Widen the dividend for the selected mode.
    always_comb begin
        lo = raw_dvd[W-1:0];
        case (mode)
            MD_FRAC:        ext = {{W{lo[W-1]}}, lo} << (W - 1);
            MD_S32, MD_U32: ext = raw_dvd;
            MD_S16:         ext = {{W{lo[W-1]}}, lo};
            default:        ext = {{W{1'b0}}, lo};
        endcase
    end

    // Signs and magnitudes of both operands.
    always_comb begin
        is_signed = mode_is_signed(mode);
        n_neg     = is_signed && ext[DW-1];
        d_neg     = is_signed && raw_dvs[W-1];
        mag       = n_neg ? (-ext) : ext;
        mag_hi    = mag[DW-1:W];
        mag_lo    = mag[W-1:0];
        dmag      = d_neg ? (-raw_dvs) : raw_dvs;
    end

endmodule

// File: rtl/itdiv_stage.sv
// One restoring-division step, purely combinational.
// Shifts the next dividend bit from the quotient shift register into the
// partial remainder and tries to subtract the divisor magnitude. The
// outcome becomes the new quotient bit.
// Assumes prem < dmag on entry (no quotient overflow).
module itdiv_stage #(
    parameter int W = 16
) (
    input  logic [W-1:0] prem,
    input  logic [W-1:0] qsh,
    input  logic [W-1:0] dmag,
    output logic [W-1:0] prem_nx,
    output logic [W-1:0] qsh_nx
);
    logic [W+1:0] trial;
    logic         fits;

    // Trial subtraction and selection.
    always_comb begin
        trial   = {1'b0, prem, qsh[W-1]} - {2'b00, dmag};
        fits    = !trial[W+1];
        prem_nx = fits ? trial[W-1:0] : {prem[W-2:0], qsh[W-1]};
        qsh_nx  = {qsh[W-2:0], fits};
    end

endmodule

// File: rtl/itdiv_fix.sv
// Result finishing, purely combinational.
// Applies the signs to the quotient and remainder magnitudes and checks
// that the quotient fits the mode's range. On a zero divisor or an
// overflow it forces both results to all ones.
// Assumes big is set when the upper dividend magnitude was not below the
// divisor magnitude (quotient wider than W bits).
module itdiv_fix #(
    parameter int W = 16
) (
    input  logic         is_signed,
    input  logic         n_neg,
    input  logic         d_neg,
    input  logic         big,
    input  logic         dz,
    input  logic [W-1:0] qmag,
    input  logic [W-1:0] rmag,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         ovf_o,
    output logic         dz_o
);
    localparam logic [W-1:0] HALF = W'(1) << (W - 1);

    logic q_neg;
    logic range_bad;

    // Range check and sign correction.
    always_comb begin
        q_neg     = n_neg ^ d_neg;
        range_bad = is_signed && (q_neg ? (qmag > HALF) : qmag[W-1]);
        dz_o      = dz;
        ovf_o     = !dz && (big || range_bad);
        if (dz || big || range_bad) begin
            quo = '1;
            rem = '1;
        end else begin
            quo = q_neg ? (-qmag) : qmag;
            rem = n_neg ? (-rmag) : rmag;
        end
    end

endmodule

// File: rtl/itdiv_top.sv
// Multi-mode iterative divider, top level.
// Latches the raw operands and the mode on an accepted start. During
// setup it takes the divisor magnitude and detects a zero divisor. The
// first step widens the dividend; W restoring steps follow, one per
// quotient bit; the final step loads the corrected results. Every step
// waits for step_en, so a divide can pause without losing state.
// Assumes W >= 4. A divide runs W+2 steps after one setup cycle.
module itdiv_top
    import itdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     mode,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    input  logic           step_en,
    output logic [W-1:0]   quotient,
    output logic [W-1:0]   remainder,
    output logic           busy,
    output logic           done,
    output logic           div_zero,
    output logic           ovf
);
    localparam int DW    = 2 * W;
    localparam int STEPS = W + 2;

    logic           load, setup, first_step, mid_step, last_step;
    logic [2:0]     mode_q;
    logic [DW-1:0]  dvd_q;
    logic [W-1:0]   dvs_q;
    logic           sgn_q, nneg_q, dneg_q, big_q, dz_q;
    logic [W-1:0]   dmag_q, prem_q, qsh_q;

    logic           p_sgn, p_nneg, p_dneg;
    logic [W-1:0]   p_hi, p_lo, p_dmag;
    logic [W-1:0]   s_prem, s_qsh;
    logic [W-1:0]   f_quo, f_rem;
    logic           f_ovf, f_dz;

    itdiv_ctrl #(.STEPS(STEPS)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .step_en    (step_en),
        .busy       (busy),
        .load       (load),
        .setup      (setup),
        .first_step (first_step),
        .mid_step   (mid_step),
        .last_step  (last_step),
        .done       (done)
    );

    itdiv_prep #(.W(W)) prep_i (
        .mode      (mode_q),
        .raw_dvd   (dvd_q),
        .raw_dvs   (dvs_q),
        .is_signed (p_sgn),
        .n_neg     (p_nneg),
        .d_neg     (p_dneg),
        .mag_hi    (p_hi),
        .mag_lo    (p_lo),
        .dmag      (p_dmag)
    );

    itdiv_stage #(.W(W)) stage_i (
        .prem    (prem_q),
        .qsh     (qsh_q),
        .dmag    (dmag_q),
        .prem_nx (s_prem),
        .qsh_nx  (s_qsh)
    );

    itdiv_fix #(.W(W)) fix_i (
        .is_signed (sgn_q),
        .n_neg     (nneg_q),
        .d_neg     (dneg_q),
        .big       (big_q),
        .dz        (dz_q),
        .qmag      (qsh_q),
        .rmag      (prem_q),
        .quo       (f_quo),
        .rem       (f_rem),
        .ovf_o     (f_ovf),
        .dz_o      (f_dz)
    );

    // Operand latch on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            dvd_q  <= '0;
            dvs_q  <= '0;
        end else if (load) begin
            mode_q <= mode;
            dvd_q  <= dividend;
            dvs_q  <= divisor;
        end
    end

    // Divisor conditioning in setup, dividend widening on the first step,
    // and the bit steps after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sgn_q  <= 1'b0;
            dneg_q <= 1'b0;
            dmag_q <= '0;
            dz_q   <= 1'b0;
            nneg_q <= 1'b0;
            big_q  <= 1'b0;
            prem_q <= '0;
            qsh_q  <= '0;
        end else if (setup) begin
            sgn_q  <= p_sgn;
            dneg_q <= p_dneg;
            dmag_q <= p_dmag;
            dz_q   <= (dvs_q == '0);
        end else if (first_step) begin
            nneg_q <= p_nneg;
            big_q  <= (p_hi >= dmag_q);
            prem_q <= p_hi;
            qsh_q  <= p_lo;
        end else if (mid_step) begin
            prem_q <= s_prem;
            qsh_q  <= s_qsh;
        end
    end

    // Result registers, written only by the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quotient  <= '0;
            remainder <= '0;
            div_zero  <= 1'b0;
            ovf       <= 1'b0;
        end else if (last_step) begin
            quotient  <= f_quo;
            remainder <= f_rem;
            div_zero  <= f_dz;
            ovf       <= f_ovf;
        end
    end

endmodule

// File: rtl/itdiv_chk.sv
// Protocol checker for itdiv_top, attached through bind.
// Watches only the ports. It counts the enabled steps of each divide to
// check the latency, and checks the pulse width, the result hold and the
// forced all-ones results.
module itdiv_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         step_en,
    input logic         busy,
    input logic         done,
    input logic         div_zero,
    input logic         ovf,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder
);
    localparam int STEPS = W + 2;
    localparam int LW    = $clog2(STEPS + 2) + 1;

    logic          busy_d;
    logic [LW-1:0] lat_q;

    // Count the enabled edges after the setup cycle of each divide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_d <= 1'b0;
            lat_q  <= '0;
        end else begin
            busy_d <= busy;
            if (busy && !busy_d)        lat_q <= '0;
            else if (busy && step_en)   lat_q <= lat_q + 1'b1;
        end
    end

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == LW'(STEPS)));

    // R6
    pause_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_en) |=> (busy && !done));

    // R7
    zero_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (quotient == '1 && remainder == '1 && !ovf));

    // R8
    ovf_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (quotient == '1 && remainder == '1 && !div_zero));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder)
                               && $stable(div_zero) && $stable(ovf) && !done));

endmodule

bind itdiv_top itdiv_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .step_en   (step_en),
    .busy      (busy),
    .done      (done),
    .div_zero  (div_zero),
    .ovf       (ovf),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/itdiv_top_tb_top.sv
module itdiv_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        step_en = 1'b1;
    logic [15:0] quotient, remainder;
    logic        busy, done, div_zero, ovf;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    itdiv_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode      (mode),
        .dividend  (dividend),
        .divisor   (divisor),
        .step_en   (step_en),
        .quotient  (quotient),
        .remainder (remainder),
        .busy      (busy),
        .done      (done),
        .div_zero  (div_zero),
        .ovf       (ovf)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected results from the requirements, in wide integer arithmetic.
    task automatic ref_div(input logic [2:0] md, input logic [31:0] dvd,
                           input logic [15:0] dvs, output logic [15:0] q,
                           output logic [15:0] r, output logic dz, output logic ov);
        longint n, d, qq, rr;
        bit sg;
        case (md)
            3'd0:    n = longint'($signed(dvd[15:0])) * 32768;
            3'd1:    n = longint'($signed(dvd));
            3'd2:    n = longint'({32'b0, dvd});
            3'd3:    n = longint'($signed(dvd[15:0]));
            default: n = longint'({48'b0, dvd[15:0]});
        endcase
        sg = (md == 3'd0) || (md == 3'd1) || (md == 3'd3);
        d  = sg ? longint'($signed(dvs)) : longint'({48'b0, dvs});
        dz = 1'b0;
        ov = 1'b0;
        q  = '1;
        r  = '1;
        if (d == 0) begin
            dz = 1'b1;
        end else begin
            qq = n / d;
            rr = n % d;
            if (sg ? (qq > 32767 || qq < -32768) : (qq > 65535)) ov = 1'b1;
            else begin
                q = qq[15:0];
                r = rr[15:0];
            end
        end
    endtask

    // One divide: optional pause of pl cycles at count pa, optional start
    // pulse while busy; checks latency, results, flags, and the done pulse.
    task automatic run_div(input string tag, input logic [2:0] md,
                           input logic [31:0] dvd, input logic [15:0] dvs,
                           input int pa, input int pl, input bit poke);
        logic [15:0] eq, er;
        logic edz, eov;
        int n = 0;
        bit seen = 0;
        ref_div(md, dvd, dvs, eq, er, edz, eov);
        @(negedge clk);
        mode = md; dividend = dvd; divisor = dvs; start = 1'b1; step_en = 1'b1;
        while (!seen && n < 300) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                start = 1'b0;
                chk("R5", "busy after start", {31'b0, busy}, 32'd1);
            end
            if (poke && n == 8) begin
                start = 1'b1; dividend = ~dvd; divisor = 16'h0001; mode = 3'd2;
            end
            if (poke && n == 9) start = 1'b0;
            if (pl > 0 && n == pa) step_en = 1'b0;
            if (pl > 0 && n == pa + pl) step_en = 1'b1;
            if (done) seen = 1;
        end
        step_en = 1'b1;
        chk(tag, "latency", n, 20 + pl);
        chk(tag, "quotient", {16'b0, quotient}, {16'b0, eq});
        chk(tag, "remainder", {16'b0, remainder}, {16'b0, er});
        chk(tag, "div_zero", {31'b0, div_zero}, {31'b0, edz});
        chk(tag, "ovf", {31'b0, ovf}, {31'b0, eov});
        chk(tag, "busy at done", {31'b0, busy}, 32'd0);
        @(negedge clk);
        chk("R10", "done one cycle", {31'b0, done}, 32'd0);
        chk("R10", "quotient held", {16'b0, quotient}, {16'b0, eq});
    endtask

    task automatic t_reset();
        chk("R11", "busy", {31'b0, busy}, 32'd0);
        chk("R11", "done", {31'b0, done}, 32'd0);
        chk("R11", "flags", {30'b0, div_zero, ovf}, 32'd0);
        chk("R11", "results", {quotient, remainder}, 32'd0);
    endtask

    task automatic t_unsigned32();
        run_div("R1", 3'd2, 32'h0001_0000, 16'h0002, 0, 0, 0);
        run_div("R1", 3'd2, 32'h1234_5678, 16'h4321, 0, 0, 0);
        run_div("R1", 3'd2, 32'h8000_FFFF, 16'hFFFF, 0, 0, 0);
    endtask

    task automatic t_signed32();
        run_div("R2", 3'd1, -32'sd1000000, 16'd100, 0, 0, 0);
        run_div("R2", 3'd1, -32'sd1000001, -16'sd100, 0, 0, 0);
        run_div("R2", 3'd1, 32'sd77777, -16'sd13, 0, 0, 0);
    endtask

    task automatic t_narrow();
        run_div("R3", 3'd4, 32'hDEAD_0064, 16'd7, 0, 0, 0);
        run_div("R3", 3'd3, 32'h5A5A_FF9C, 16'd7, 0, 0, 0);
        run_div("R3", 3'd3, 32'h0000_0064, -16'sd7, 0, 0, 0);
        run_div("R3", 3'd3, 32'hFFFF_8000, 16'd1, 0, 0, 0);
        run_div("R3", 3'd6, 32'hFFFF_FFFE, 16'd3, 0, 0, 0);
    endtask

    task automatic t_frac();
        run_div("R4", 3'd0, 32'h0000_2000, 16'h4000, 0, 0, 0);
        run_div("R4", 3'd0, 32'hFFFF_E000, 16'h4000, 0, 0, 0);
        run_div("R4", 3'd0, 32'h0000_C000, 16'h4000, 0, 0, 0);
        run_div("R4", 3'd0, 32'h0000_1000, 16'h3000, 0, 0, 0);
        run_div("R4", 3'd0, 32'h0000_F123, 16'hA000, 0, 0, 0);
    endtask

    task automatic t_zero();
        run_div("R7", 3'd2, 32'h1234_5678, 16'h0000, 0, 0, 0);
        run_div("R7", 3'd0, 32'h0000_4000, 16'h0000, 0, 0, 0);
    endtask

    task automatic t_ovf();
        run_div("R8", 3'd3, 32'h0000_8000, 16'hFFFF, 0, 0, 0);
        run_div("R8", 3'd2, 32'h0002_0000, 16'h0002, 0, 0, 0);
        run_div("R8", 3'd1, 32'h4000_0000, 16'h0002, 0, 0, 0);
        run_div("R8", 3'd0, 32'h0000_4000, 16'h2000, 0, 0, 0);
        run_div("R8", 3'd0, 32'h0000_8000, 16'h8000, 0, 0, 0);
    endtask

    task automatic t_pause();
        run_div("R6", 3'd1, -32'sd123456, 16'd321, 5, 7, 0);
        run_div("R6", 3'd0, 32'h0000_1234, 16'h5678, 12, 3, 0);
    endtask

    task automatic t_busy_start();
        run_div("R9", 3'd4, 32'h0000_03E8, 16'd9, 0, 0, 1);
    endtask

    task automatic t_hold();
        logic [15:0] q0, r0;
        q0 = quotient;
        r0 = remainder;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            dividend = 32'h1357_9BDF + i;
            divisor = 16'h0003;
            mode = 3'(i);
            step_en = i[0];
        end
        @(negedge clk);
        step_en = 1'b1;
        chk("R10", "quotient stable idle", {16'b0, quotient}, {16'b0, q0});
        chk("R10", "remainder stable idle", {16'b0, remainder}, {16'b0, r0});
        chk("R10", "no done while idle", {30'b0, done, busy}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_unsigned32();
        t_signed32();
        t_narrow();
        t_frac();
        t_zero();
        t_ovf();
        t_pause();
        t_busy_start();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule